// File: doc/BRIEF.md
# Line-Cycle Synchronous Energy Accumulator

This block adds up three per-sample energy increments over a window that is a whole number of line zero crossings long. The three increments are active energy, reactive energy and apparent energy. At the end of each window it copies each running sum into a held result output. All three results therefore cover exactly the same stretch of time. A later stage can then form a vector sum from the active and reactive totals and compare it with the apparent total over that identical interval.

The window length comes from a 16-bit crossing count. The first crossing seen after a non-zero count is programmed starts the first window. Each later window begins in the cycle that closes the previous one. Each energy type has its own enable bit, so any subset of the three can run while sharing one window. A sticky completion flag marks every window close and is cleared by a one-cycle clear pulse. A crossing count of zero stops all windowing.

Top module: `linecyc_energy_acc`

## Requirements
- R1: During and straight after reset, all three totals and the completion flag read zero.
- R2: The active increment is taken as two's complement and sign-extended. A sample adds to the sum only in a cycle with `sample_valid` high. A window runs from the crossing cycle that opens it (that cycle's sample included) up to the crossing cycle that closes it (that cycle's sample excluded). The active total at the close equals the sum of the window's valid active samples, modulo 2^ACC_W.
- R3: The reactive increment is two's complement and is summed and latched by the same rule as R2.
- R4: The apparent increment is unsigned. An increment with its top bit set adds a large positive value, and the apparent total never decreases within a window.
- R5: The crossing that closes a window is the `zx_count`-th crossing after the opening crossing. All enabled totals take their new values on the clock edge of that crossing cycle, and none changes earlier.
- R6: `lane_en` bit 0 enables active, bit 1 enables reactive and bit 2 enables apparent accumulation. A disabled lane keeps its total unchanged and holds its running sum at zero.
- R7: The sample in a closing crossing cycle belongs to the next window, so back-to-back windows lose and repeat no sample.
- R8: The crossing counter reloads from `zx_count` at each window opening and close. A new count written mid-window takes effect only from the next window.
- R9: While `zx_count` is zero nothing latches, the totals and flag hold, and the running sums clear. After a non-zero count is set again, the next crossing opens a new window.
- R10: `cycle_done` is set by every window close and cleared by `done_clr` high for one cycle. A close in the same cycle as a clear leaves the flag set.
- R11: The totals change only at a window close. No other activity clears or alters them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Increments are valid this cycle |
| act_inc | input | IN_W | Active energy increment, signed |
| react_inc | input | IN_W | Reactive energy increment, signed |
| app_inc | input | IN_W | Apparent energy increment, unsigned |
| zx_strobe | input | 1 | One-cycle zero-crossing strobe |
| zx_count | input | 16 | Crossings per window; 0 stops windowing |
| lane_en | input | 3 | Enables: bit0 active, bit1 reactive, bit2 apparent |
| done_clr | input | 1 | Clear pulse for the completion flag |
| act_total | output | ACC_W | Latched active total, two's complement |
| react_total | output | ACC_W | Latched reactive total, two's complement |
| app_total | output | ACC_W | Latched apparent total, unsigned |
| cycle_done | output | 1 | Sticky window-complete flag |

## Verification
At each window close the bench changes the increments. A design that put the closing sample into the old window would latch one extra sample and then drop it from the next total. The count is changed mid-window, so a design that picked up the new count at once would close early. One lane is disabled at a window edge: it must keep the value it latched earlier rather than pick up a fresh sum. An apparent increment with its top bit set catches any sign extension on that lane. A zero count held across several crossings must neither latch nor keep counting, and a close that coincides with a flag clear must leave the flag set.

// File: rtl/lcea_pkg.sv
package lcea_pkg;

    localparam int CNT_W = 16;
    localparam int LANES = 3;

    // lane order matches the enable-bit positions
    typedef enum int {
        LANE_ACT   = 0,
        LANE_REACT = 1,
        LANE_APP   = 2
    } lane_e;

    // what every running sum does this cycle
    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,   // no window: hold sums at zero
        OP_START = 2'd1,   // opening crossing: sum <= sample
        OP_ADD   = 2'd2,   // inside window: sum <= sum + sample
        OP_LATCH = 2'd3    // closing crossing: total <= sum, sum <= sample
    } acc_op_e;

    typedef struct packed {
        logic             synced;
        logic [CNT_W-1:0] remain;
    } win_state_t;

endpackage

// File: rtl/lcea_window_ctrl.sv
module lcea_window_ctrl
    import lcea_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             zx_strobe,
    input  logic [CNT_W-1:0] zx_count,
    output acc_op_e          op
);

    win_state_t st;

    always_comb begin
        if (zx_count == '0)
            op = OP_CLEAR;
        else if (!st.synced)
            op = zx_strobe ? OP_START : OP_CLEAR;
        else if (zx_strobe && st.remain == CNT_W'(1))
            op = OP_LATCH;
        else
            op = OP_ADD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            unique case (op)
                OP_CLEAR: st <= '0;
                OP_START, OP_LATCH: begin
                    st.synced <= 1'b1;
                    st.remain <= zx_count;
                end
                OP_ADD: if (zx_strobe) st.remain <= st.remain - CNT_W'(1);
            endcase
        end
    end

    AST_SYNCED_COUNT_LIVE: assert property (@(posedge clk) disable iff (rst)
        st.synced |-> (st.remain != '0)); // R8

    AST_NO_SYNC_ON_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (zx_count == '0) |=> !st.synced); // R9

endmodule

// File: rtl/lcea_lane.sv
module lcea_lane
    import lcea_pkg::*;
#(
    parameter int IN_W      = 16,
    parameter int ACC_W     = 32,
    parameter bit SIGNED_IN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             valid,
    input  logic [IN_W-1:0]  inc,
    input  acc_op_e          op,
    output logic [ACC_W-1:0] total
);

    localparam int EXT_W = ACC_W - IN_W;

    logic [ACC_W-1:0] ext;
    logic [ACC_W-1:0] sample;
    logic [ACC_W-1:0] sum;

    generate
        if (SIGNED_IN) begin : g_signed
            assign ext = {{EXT_W{inc[IN_W-1]}}, inc};
        end else begin : g_unsigned
            assign ext = {{EXT_W{1'b0}}, inc};
        end
    endgenerate

    assign sample = valid ? ext : '0;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            sum <= '0;
        end else begin
            unique case (op)
                OP_CLEAR:           sum <= '0;
                OP_START, OP_LATCH: sum <= sample;
                OP_ADD:             sum <= sum + sample;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            total <= '0;
        else if (en && op == OP_LATCH)
            total <= sum;
    end

    AST_TOTAL_ONLY_AT_CLOSE: assert property (@(posedge clk) disable iff (rst)
        (op != OP_LATCH) |=> $stable(total)); // R11

    AST_DISABLED_LANE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(total)); // R6

    AST_DISABLED_SUM_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !en |=> (sum == '0)); // R6

endmodule

// File: rtl/linecyc_energy_acc.sv
module linecyc_energy_acc
    import lcea_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_valid,
    input  logic [IN_W-1:0]  act_inc,
    input  logic [IN_W-1:0]  react_inc,
    input  logic [IN_W-1:0]  app_inc,
    input  logic             zx_strobe,
    input  logic [CNT_W-1:0] zx_count,
    input  logic [LANES-1:0] lane_en,
    input  logic             done_clr,
    output logic [ACC_W-1:0] act_total,
    output logic [ACC_W-1:0] react_total,
    output logic [ACC_W-1:0] app_total,
    output logic             cycle_done
);

    acc_op_e          op;
    logic [IN_W-1:0]  inc_bus [LANES];
    logic [ACC_W-1:0] tot_bus [LANES];

    assign inc_bus[LANE_ACT]   = act_inc;
    assign inc_bus[LANE_REACT] = react_inc;
    assign inc_bus[LANE_APP]   = app_inc;

    lcea_window_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .zx_strobe (zx_strobe),
        .zx_count  (zx_count),
        .op        (op)
    );

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            lcea_lane #(
                .IN_W      (IN_W),
                .ACC_W     (ACC_W),
                .SIGNED_IN (g != int'(LANE_APP))
            ) u_lane (
                .clk   (clk),
                .rst   (rst),
                .en    (lane_en[g]),
                .valid (sample_valid),
                .inc   (inc_bus[g]),
                .op    (op),
                .total (tot_bus[g])
            );
        end
    endgenerate

    assign act_total   = tot_bus[LANE_ACT];
    assign react_total = tot_bus[LANE_REACT];
    assign app_total   = tot_bus[LANE_APP];

    always_ff @(posedge clk) begin
        if (rst)
            cycle_done <= 1'b0;
        else if (op == OP_LATCH)
            cycle_done <= 1'b1;
        else if (done_clr)
            cycle_done <= 1'b0;
    end

    AST_FLAG_ON_CLOSE: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LATCH) |=> cycle_done); // R10

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (done_clr && op != OP_LATCH) |=> !cycle_done); // R10

    AST_ZERO_COUNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (zx_count == '0) |=> ($stable(act_total) && $stable(react_total)
                              && $stable(app_total))); // R9

    AST_CLOSE_NEEDS_CROSSING: assert property (@(posedge clk) disable iff (rst)
        !zx_strobe |=> ($stable(act_total) && $stable(react_total)
                        && $stable(app_total))); // R5

endmodule

// File: tb/linecyc_energy_acc_bench.sv
module linecyc_energy_acc_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_valid = 1'b0;
    logic [15:0] act_inc = '0, react_inc = '0, app_inc = '0;
    logic        zx_strobe = 1'b0;
    logic [15:0] zx_count = '0;
    logic [2:0]  lane_en = '0;
    logic        done_clr = 1'b0;
    logic [31:0] act_total, react_total, app_total;
    logic        cycle_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    linecyc_energy_acc u_linecyc_energy_acc (
        .clk(clk), .rst(rst), .sample_valid(sample_valid),
        .act_inc(act_inc), .react_inc(react_inc), .app_inc(app_inc),
        .zx_strobe(zx_strobe), .zx_count(zx_count), .lane_en(lane_en),
        .done_clr(done_clr), .act_total(act_total), .react_total(react_total),
        .app_total(app_total), .cycle_done(cycle_done)
    );

    // behavioural reference
    logic [31:0] m_sum [3];
    logic [31:0] m_tot [3];
    bit          m_flag;
    bit          m_sync;
    int          m_left;

    function automatic logic [31:0] incr(int lane);
        if (!sample_valid) return 32'd0;
        case (lane)
            0: return {{16{act_inc[15]}}, act_inc};
            1: return {{16{react_inc[15]}}, react_inc};
            default: return {16'd0, app_inc};
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 3; i++) begin m_sum[i] = 0; m_tot[i] = 0; end
            m_flag = 0; m_sync = 0; m_left = 0;
        end else begin
            bit closing;
            closing = 0;
            if (zx_count == 0) begin
                m_sync = 0; m_left = 0;
                for (int i = 0; i < 3; i++) m_sum[i] = 0;
            end else if (!m_sync) begin
                for (int i = 0; i < 3; i++) m_sum[i] = 0;
                if (zx_strobe) begin
                    m_sync = 1; m_left = zx_count;
                    for (int i = 0; i < 3; i++) m_sum[i] = incr(i);
                end
            end else if (zx_strobe && m_left == 1) begin
                closing = 1; m_left = zx_count;
                for (int i = 0; i < 3; i++) begin
                    if (lane_en[i]) m_tot[i] = m_sum[i];
                    m_sum[i] = incr(i);
                end
            end else begin
                if (zx_strobe) m_left = m_left - 1;
                for (int i = 0; i < 3; i++) m_sum[i] = m_sum[i] + incr(i);
            end
            for (int i = 0; i < 3; i++) if (!lane_en[i]) m_sum[i] = 0;
            if (closing) m_flag = 1;
            else if (done_clr) m_flag = 0;
        end
    end

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // every-cycle comparison with the reference
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R2 active vs model", act_total, m_tot[0]);
            chk("R3 reactive vs model", react_total, m_tot[1]);
            chk("R4 apparent vs model", app_total, m_tot[2]);
            chk("R10 flag vs model", {31'd0, cycle_done}, {31'd0, m_flag});
        end
    end

    task automatic cyc(bit zx);
        zx_strobe = zx;
        @(posedge clk);
        @(negedge clk);
        zx_strobe = 1'b0;
    endtask

    task automatic period();
        cyc(1'b1);
        repeat (4) cyc(1'b0);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R5 watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 act reset", act_total, 32'd0);
        chk("R1 react reset", react_total, 32'd0);
        chk("R1 app reset", app_total, 32'd0);
        chk("R1 flag reset", {31'd0, cycle_done}, 32'd0);
        rst = 1'b0;

        sample_valid = 1'b1;
        lane_en  = 3'b111;
        zx_count = 16'd3;
        act_inc  = 16'd10;
        react_inc = 16'hFFFD;      // -3
        app_inc  = 16'h9000;       // top bit set, unsigned
        cyc(1'b0); cyc(1'b0);      // before first crossing: ignored
        repeat (3) period();
        // R5: nothing latched before the closing crossing
        chk("R5 act not early", act_total, 32'd0);
        act_inc = 16'd7;           // closing-cycle sample belongs to next window
        react_inc = 16'hFFFB;      // -5
        cyc(1'b1);
        chk("R2 act window1", act_total, 32'd150);
        chk("R3 react window1", react_total, 32'hFFFF_FFD3);
        chk("R4 app window1", app_total, 32'h0008_7000);
        chk("R5 flag at close", {31'd0, cycle_done}, 32'd1);

        repeat (4) cyc(1'b0);
        period();
        zx_count = 16'd2;          // R8: must not shorten current window
        period();
        cyc(1'b1);
        chk("R7 act window2", act_total, 32'd105);
        chk("R8 react window2", react_total, 32'hFFFF_FFB5);
        chk("R8 app window2", app_total, 32'h0008_7000);

        lane_en = 3'b101;          // reactive off
        repeat (4) cyc(1'b0);
        period();
        cyc(1'b1);
        chk("R8 act two-crossing window", act_total, 32'd70);
        chk("R6 react held while disabled", react_total, 32'hFFFF_FFB5);
        chk("R4 app window3", app_total, 32'h0005_A000);

        done_clr = 1'b1;
        cyc(1'b0);
        done_clr = 1'b0;
        chk("R10 flag cleared", {31'd0, cycle_done}, 32'd0);

        zx_count = 16'd0;
        repeat (3) period();
        chk("R9 act held", act_total, 32'd70);
        chk("R9 app held", app_total, 32'h0005_A000);
        chk("R9 no flag", {31'd0, cycle_done}, 32'd0);

        zx_count = 16'd2;
        lane_en = 3'b111;
        cyc(1'b0); cyc(1'b0);
        period();
        period();
        done_clr = 1'b1;
        cyc(1'b1);
        done_clr = 1'b0;
        chk("R10 set beats clear", {31'd0, cycle_done}, 32'd1);
        chk("R9 act after restart", act_total, 32'd70);
        chk("R6 react fresh after enable", react_total, 32'hFFFF_FFCE);
        chk("R11 app after restart", app_total, 32'h0005_A000);

        // mixed traffic, model comparison only
        for (int i = 0; i < 300; i++) begin
            sample_valid = (i % 3) != 0;
            act_inc  = 16'(i * 37);
            react_inc = 16'(16'hFF00 + i);
            app_inc  = 16'(i * 211);
            if (i == 150) zx_count = 16'd4;
            cyc((i % 7) == 0);
        end
        summary();
    end

endmodule